// File: doc/BRIEF.md
# SD Card Clock Control Unit

This block is the clock control register and card clock generator of an SD host controller. A 16-bit control word holds an internal-clock enable, a hardware-owned "internal clock stable" flag, a card-clock enable and an 8-bit divisor select field. From the base clock it derives the card clock. The card clock is either the base clock itself or the base clock divided by a power of two from 2 to 256, and it is held low whenever it is not allowed to run.

Software brings the clock up in a fixed order. It sets the internal enable, polls until the stable flag reads back as set, and then sets the card-clock enable together with the divisor it wants. The divisor can be changed while the card clock runs. The change is applied only at the start of a low phase, and stopping the clock lets the current high phase finish, so the card never sees a shortened pulse.

Top module: `sdclk_ctrl`

## Requirements
- R1: A write stores bit 0 (internal enable), bit 2 (card-clock enable) and bits 15:8 (divisor select). On read these come back in the same positions, bit 1 shows the stable flag, and every other bit reads 0.
- R2: Bit 1 is read-only. Writing it to 1 does not set the flag, and writing it to 0 while the flag is set does not clear it.
- R3: The stable flag reads 1 exactly STABLE_DLY base-clock cycles after the edge at which the internal enable was stored as 1, and reads 0 before that.
- R4: The stable flag reads 0 from the same edge at which the internal enable is stored as 0.
- R5: The card clock stays low unless the internal enable, the stable flag and the card-clock enable are all 1.
- R6: When the select field is 0x00, the running card clock equals the base clock: high in the base clock's high phase and low in its low phase.
- R7: When the select field has only bit i set, the running card clock has a period of 2^(i+1) base cycles, with 2^i cycles high and 2^i cycles low (0x01 gives /2, up to 0x80 giving /256).
- R8: When the select field has more than one bit set, only the highest set bit decides the divisor.
- R9: A new divisor takes effect only at the start of a card-clock low phase. Every high pulse seen across a change has the full length of either the old setting or the new one.
- R10: When the card clock is disabled while high, it finishes its full high phase and then stays low.
- R11: A synchronous reset clears both enables, the stable flag and the select field, so the register reads 0 and the card clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | REG_W | Control word to write |
| rd_data | output | REG_W | Current control word, including the stable flag |
| card_clk | output | 1 | Generated card clock |

## Verification
A write is stored at the first base-clock rising edge after wr_en is driven, and the read value reflects it straight away, so the bench samples rd_data 2 ns after that edge. The stable flag is due STABLE_DLY edges after the enabling write, and the bench samples it one edge before that point and at that point. In divided mode the card clock changes only at rising edges, so the bench samples it 2 ns after each edge and measures the lengths of its high and low runs, discarding the first period after any change. In pass-through mode the bench samples both halves of each base cycle, and it allows a two-cycle settling gap after enabling or disabling before checking that the output follows the base clock or stays low.

// File: rtl/sdcc_pkg.sv
package sdcc_pkg;
   // Bit positions inside the control word; software depends on these.
   localparam int IEN_POS = 0;
   localparam int STB_POS = 1;
   localparam int CEN_POS = 2;
   localparam int SEL_LSB = 8;
endpackage

// File: rtl/sdcc_regs.sv
module sdcc_regs
   import sdcc_pkg::*;
#(
   parameter int REG_W = 16,
   parameter int SEL_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             stable,
   output logic             ien_q,
   output logic             ien_d,
   output logic             cen_q,
   output logic [SEL_W-1:0] sel_q,
   output logic [REG_W-1:0] rd_data
);
   // Next value of the internal enable, used by the stable sequencer
   always_comb begin
      ien_d = wr_en ? wr_data[IEN_POS] : ien_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ien_q <= 1'b0;
         cen_q <= 1'b0;
         sel_q <= '0;
      end else if (wr_en) begin
         ien_q <= wr_data[IEN_POS];
         cen_q <= wr_data[CEN_POS];
         sel_q <= wr_data[SEL_LSB +: SEL_W];
      end
   end

   always_comb begin
      rd_data                    = '0;
      rd_data[IEN_POS]           = ien_q;
      rd_data[STB_POS]           = stable;
      rd_data[CEN_POS]           = cen_q;
      rd_data[SEL_LSB +: SEL_W]  = sel_q;
   end
endmodule

// File: rtl/sdcc_stable.sv
module sdcc_stable #(
   parameter int STABLE_DLY = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic ien_q,
   input  logic ien_d,
   output logic stable
);
   localparam int CW = $clog2(STABLE_DLY + 1);
   localparam logic [CW-1:0] LAST = CW'(STABLE_DLY - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst || !ien_d) begin
         stable <= 1'b0;
         cnt    <= '0;
      end else if (ien_q && !stable) begin
         if (cnt == LAST) begin
            stable <= 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/sdcc_divsel.sv
module sdcc_divsel #(
   parameter int SEL_W = 8
) (
   input  logic [SEL_W-1:0] sel,
   output logic [SEL_W-1:0] onehot
);
   // Priority decode: the highest set bit wins
   for (genvar i = 0; i < SEL_W; i++) begin : g_bit
      if (i == SEL_W - 1) begin : g_top
         assign onehot[i] = sel[i];
      end else begin : g_low
         assign onehot[i] = sel[i] & ~(|sel[SEL_W-1:i+1]);
      end
   end
endmodule

// File: rtl/sdcc_clkgen.sv
module sdcc_clkgen #(
   parameter int SEL_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             run,
   input  logic [SEL_W-1:0] sel_req,
   output logic [SEL_W-1:0] sel_act,
   output logic             div_q,
   output logic             card_clk
);
   localparam int CW = (SEL_W > 1) ? SEL_W - 1 : 1;

   logic [CW-1:0]    cnt;
   logic [CW-1:0]    half_m1;
   logic [SEL_W-1:0] eff_sel;
   logic             take_new;
   logic             bypass;
   logic             byp_en_n;

   // A new select is accepted only at the first cycle of a low phase
   always_comb begin
      take_new = !div_q && (cnt == '0);
      eff_sel  = take_new ? sel_req : sel_act;
      bypass   = (eff_sel == '0);
      half_m1  = '0;
      for (int i = 0; i < SEL_W; i++) begin
         if (eff_sel[i]) begin
            half_m1 = half_m1 | CW'((32'd1 << i) - 32'd1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sel_act <= '0;
         div_q   <= 1'b0;
         cnt     <= '0;
      end else begin
         if (take_new) begin
            sel_act <= sel_req;
         end
         if (bypass) begin
            div_q <= 1'b0;
            cnt   <= '0;
         end else if (div_q) begin
            // High phase always completes
            if (cnt == half_m1) begin
               div_q <= 1'b0;
               cnt   <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end else if (!run) begin
            cnt <= '0;
         end else if (cnt == half_m1) begin
            div_q <= 1'b1;
            cnt   <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // Pass-through gate updated while the base clock is low
   always_ff @(negedge clk) begin
      if (rst) begin
         byp_en_n <= 1'b0;
      end else begin
         byp_en_n <= run && (sel_act == '0);
      end
   end

   assign card_clk = (clk & byp_en_n) | div_q;
endmodule

// File: rtl/sdclk_ctrl.sv
module sdclk_ctrl
   import sdcc_pkg::*;
#(
   parameter int REG_W      = 16,
   parameter int SEL_W      = 8,
   parameter int STABLE_DLY = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   output logic             card_clk
);
   if (SEL_W < 1 || SEL_W > 12) begin : g_bad_sel
      $error("SEL_W must be within 1..12");
   end
   if (REG_W < SEL_LSB + SEL_W) begin : g_bad_reg
      $error("REG_W too narrow for the select field");
   end
   if (STABLE_DLY < 1) begin : g_bad_dly
      $error("STABLE_DLY must be at least 1");
   end

   logic             ien_q;
   logic             ien_d;
   logic             cen_q;
   logic             stable_w;
   logic             run_w;
   logic             div_q_w;
   logic [SEL_W-1:0] sel_q;
   logic [SEL_W-1:0] sel_dec;
   logic [SEL_W-1:0] sel_act_w;

   sdcc_regs #(.REG_W(REG_W), .SEL_W(SEL_W)) u_regs (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .stable  (stable_w),
      .ien_q   (ien_q),
      .ien_d   (ien_d),
      .cen_q   (cen_q),
      .sel_q   (sel_q),
      .rd_data (rd_data)
   );

   sdcc_stable #(.STABLE_DLY(STABLE_DLY)) u_stable (
      .clk    (clk),
      .rst    (rst),
      .ien_q  (ien_q),
      .ien_d  (ien_d),
      .stable (stable_w)
   );

   sdcc_divsel #(.SEL_W(SEL_W)) u_divsel (
      .sel    (sel_q),
      .onehot (sel_dec)
   );

   assign run_w = ien_q & stable_w & cen_q;

   sdcc_clkgen #(.SEL_W(SEL_W)) u_clkgen (
      .clk      (clk),
      .rst      (rst),
      .run      (run_w),
      .sel_req  (sel_dec),
      .sel_act  (sel_act_w),
      .div_q    (div_q_w),
      .card_clk (card_clk)
   );
endmodule

// File: rtl/sdclk_ctrl_chk.sv
module sdclk_ctrl_chk
   import sdcc_pkg::*;
#(
   parameter int REG_W = 16,
   parameter int SEL_W = 8
) (
   input logic             clk,
   input logic             rst,
   input logic [REG_W-1:0] rd_data,
   input logic             run,
   input logic             div_q,
   input logic [SEL_W-1:0] sel_dec,
   input logic [SEL_W-1:0] sel_act
);
   // R2: flag can only be up while the internal enable is up
   a_r2_stable_needs_en: assert property (@(posedge clk) disable iff (rst)
      rd_data[STB_POS] |-> rd_data[IEN_POS]);

   // R3: flag rises only after a cycle with the enable already stored
   a_r3_rise_after_en: assert property (@(posedge clk) disable iff (rst)
      $rose(rd_data[STB_POS]) |-> $past(rd_data[IEN_POS]));

   // R4: clearing the enable drops the flag on the same edge
   a_r4_clear_with_en: assert property (@(posedge clk) disable iff (rst)
      $fell(rd_data[IEN_POS]) |-> !rd_data[STB_POS]);

   // R5: a stopped divided clock does not start a new high phase
   a_r5_held_low: assert property (@(posedge clk) disable iff (rst)
      (!run && !div_q) |=> !div_q);

   // R8: decoded select is at most one-hot
   a_r8_onehot_sel: assert property (@(posedge clk) disable iff (rst)
      $onehot0(sel_dec));

   // R9: the active divisor only switches from a low phase
   a_r9_switch_low: assert property (@(posedge clk) disable iff (rst)
      !$stable(sel_act) |-> !$past(div_q));

   // R11: after reset the register reads zero
   a_r11_reset_clear: assert property (@(posedge clk)
      rst |=> (rd_data == '0));
endmodule

bind sdclk_ctrl sdclk_ctrl_chk #(.REG_W(REG_W), .SEL_W(SEL_W)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .rd_data (rd_data),
   .run     (run_w),
   .div_q   (div_q_w),
   .sel_dec (sel_dec),
   .sel_act (sel_act_w)
);

// File: tb/sim_sdclk_ctrl.sv
`timescale 1ns/1ps
module sim_sdclk_ctrl;
   localparam int DLY = 6;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        card_clk;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   sdclk_ctrl #(.REG_W(16), .SEL_W(8), .STABLE_DLY(DLY)) u0 (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .card_clk(card_clk)
   );

   function automatic int exp_half(input logic [7:0] s);
      for (int i = 7; i >= 0; i--) if (s[i]) return 1 << i;
      return 0;
   endfunction

   function automatic logic [15:0] exp_rd(input bit ien, input bit stb,
                                          input bit cen, input logic [7:0] s);
      return {s, 5'b0, cen, stb, ien};
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] d);
      @(negedge clk); wr_en = 1'b1; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic step(output logic v);
      @(posedge clk); #2; v = card_clk;
   endtask

   // Measure one high run and one low run of the divided card clock
   task automatic meas(output int hi, output int lo);
      logic v; int g;
      hi = -1; lo = -1; g = 0;
      step(v);
      while (v && g < 2000) begin step(v); g++; end
      while (!v && g < 2000) begin step(v); g++; end
      if (g >= 2000) return;
      hi = 0;
      while (v && g < 4000) begin hi++; step(v); g++; end
      lo = 0;
      while (!v && g < 4000) begin lo++; step(v); g++; end
   endtask

   // Every complete high run in the window must be a or b cycles long
   task automatic observe(input int n, input int a, input int b, input string req);
      logic v; bit started = 0; int len = 0;
      for (int k = 0; k < n; k++) begin
         step(v);
         if (!v) begin
            if (started && len > 0) begin
               checks++;
               if (len != a && len != b) begin
                  errors++;
                  $display("FAIL %s actual=%0d expected=%0d or %0d", req, len, a, b);
               end
            end
            started = 1; len = 0;
         end else if (started) len++;
      end
   endtask

   task automatic check_low(input int n, input string req);
      for (int k = 0; k < n; k++) begin
         @(posedge clk); #2; chk(req, card_clk, 0);
         #5; chk(req, card_clk, 0);
      end
   endtask

   task automatic check_bypass(input int n, input string req);
      repeat (3) @(posedge clk);
      for (int k = 0; k < n; k++) begin
         @(posedge clk); #2; chk(req, card_clk, 1);
         #5; chk(req, card_clk, 0);
      end
   endtask

   task automatic check_div(input logic [7:0] s, input string req);
      int hi, lo, h;
      h = exp_half(s);
      meas(hi, lo);
      meas(hi, lo);
      chk({req, " high"}, hi, h);
      chk({req, " low"}, lo, h);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] s;
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;
      @(posedge clk); #2;
      // R11 reset state
      chk("R11 reset rd", rd_data, 0);
      check_low(4, "R11 reset clk");

      // R2: stable bit cannot be written
      wr(16'h0002);
      chk("R2 write stable ignored", rd_data, 0);

      // R3 / R5: stable sequencing, clock held low before stable
      wr(16'h0005);
      chk("R3 stable low at write", rd_data[1], 0);
      for (int j = 1; j <= DLY; j++) begin
         @(posedge clk); #2;
         chk("R3 stable timing", rd_data[1], (j >= DLY) ? 1 : 0);
         if (j < DLY) chk("R5 low before stable", card_clk, 0);
      end
      // R6 pass-through
      check_bypass(8, "R6 bypass");
      // R2: writing 0 to bit 1 keeps the flag
      wr(16'h0005);
      chk("R2 clear ignored", rd_data, 16'h0007);

      // R4
      wr(16'h0004);
      chk("R4 stable clears with en", rd_data, 16'h0004);
      check_low(10, "R5 no internal enable");

      // R1 readback of all-ones
      wr(16'hFFFF);
      chk("R1 readback", rd_data, exp_rd(1, 0, 1, 8'hFF));
      repeat (DLY) @(posedge clk); #2;
      chk("R1 readback stable", rd_data, exp_rd(1, 1, 1, 8'hFF));
      // R8: 0xFF behaves as /256
      check_div(8'hFF, "R8 multi-bit FF");

      // R7: every one-hot setting
      for (int i = 0; i < 8; i++) begin
         s = 8'(1 << i);
         wr({s, 8'h05});
         check_div(s, $sformatf("R7 sel %0h", s));
      end
      // R8 directed
      wr({8'h0B, 8'h05});
      check_div(8'h0B, "R8 sel 0B");

      // R9: /256 -> /2 and /2 -> /256 across the change
      wr({8'h80, 8'h05});
      check_div(8'h80, "R9 settle");
      fork
         observe(900, 128, 1, "R9 switch down");
         begin repeat (100) @(posedge clk); wr({8'h01, 8'h05}); end
      join
      fork
         observe(900, 128, 1, "R9 switch up");
         begin repeat (7) @(posedge clk); wr({8'h80, 8'h05}); end
      join

      // R10: stop while running /16
      wr({8'h08, 8'h05});
      check_div(8'h08, "R10 settle");
      fork
         observe(120, 8, 8, "R10 finish high");
         begin repeat (37) @(posedge clk); wr({8'h08, 8'h01}); end
      join
      check_low(20, "R5 card clock disabled");
      wr({8'h00, 8'h01});
      check_low(10, "R5 bypass disabled");

      // Random select values
      for (int n = 0; n < 14; n++) begin
         s = (n % 3 == 0) ? 8'(1 << ($urandom % 8)) : 8'($urandom);
         wr({s, 8'h05});
         if (exp_half(s) == 0) check_bypass(6, "R6 random bypass");
         else check_div(s, $sformatf("R7 R8 random sel %0h", s));
      end

      // R11: reset while running
      @(negedge clk); rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk); rst = 1'b0;
      @(posedge clk); #2;
      chk("R11 reset mid-run", rd_data, 0);
      check_low(6, "R11 clock low after reset");

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule